// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Wait States

This block runs one read or one write transfer at a time on a simple 8-bit style external processor bus. Each clock period is one T state. A cycle moves through an address phase (T1, with the address-latch strobe high), a strobe phase (T2), any number of inserted wait states (TW) and a final phase (T3), and then returns to idle. The core side starts a cycle with a valid/acknowledge handshake. A one-cycle completion pulse ends the transfer, and for reads it comes with the captured data.

Slow memories and peripherals stretch the cycle by holding the ready input low. While the sequencer waits, every bus output keeps its value. A synchronous reset cannot pull the sequencer out of a wait state while ready is still low. The sequencer leaves the wait only when ready is seen high.

Top module: `bus_cycle_seq`

## Requirements
- R1: When no cycle is in progress (and during reset), `bus_ale` is 0, `bus_rd_n` and `bus_wr_n` are 1, `bus_wdata_oe` is 0 and `bus_addr` is all zeros.
- R2: `req_ack` is high only in idle, with reset released and `req_valid` high, and the request is then taken. Address, direction and write data are stored at that edge. Later changes on the request inputs, and `req_valid` raised while a cycle runs, have no effect on the current cycle.
- R3: In the clock after acceptance (T1), `bus_ale` is 1 for exactly one clock. `bus_addr` carries the stored address from T1 until the end of T3.
- R4: From T2 until the end of T3, `bus_rd_n` is low for a read (`req_write`=0) or `bus_wr_n` is low for a write (`req_write`=1). For a write, `bus_wdata_oe` is 1 and `bus_wdata` carries the stored data over the same span. Otherwise `bus_wdata_oe` is 0.
- R5: With `bus_ready` high, T1 to the end of T3 takes exactly three clocks. `done` is high for exactly one clock, in the clock after T3.
- R6: `bus_ready` is sampled at the clock edge that ends T2. If it is low there, a wait state follows. It is sampled again at each edge that ends a wait state. Each low sample adds exactly one clock, with no upper limit.
- R7: During every wait state, `bus_ale`, `bus_addr`, `bus_wdata`, `bus_wdata_oe`, `bus_rd_n` and `bus_wr_n` hold the values they had in the clock before.
- R8: For a read, `bus_rdata` is captured at the edge that ends T3 and appears on `rdata` in the same clock as `done`.
- R9: `rst_n` is a synchronous active-low reset that returns the sequencer to idle at the next edge. The exception is a wait state with `bus_ready` low: the sequencer stays in the wait with its outputs unchanged. Once `bus_ready` is seen high with reset still asserted, it goes to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T state per period |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | Request accepted this clock |
| done | output | 1 | One-clock cycle completion pulse |
| rdata | output | DW | Data captured by the last read |
| bus_ale | output | 1 | Address latch strobe, high in T1 |
| bus_addr | output | AW | External address |
| bus_wdata | output | DW | External write data |
| bus_wdata_oe | output | 1 | Write data output enable |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ready | input | 1 | Ready from memory or peripheral |
| bus_rdata | input | DW | External read data |

## Verification
The bench builds the sequencer with a 12-bit address and 8-bit data, so that the inverted address and data it drives after acceptance are distinct values that a missing capture would expose. Runs of zero, one, two and five wait states cover a ready sampled high at T2 and an unbounded wait loop. The end-of-cycle pulse checks exactly when each cycle finishes. A reset raised inside a held wait exercises the one case where reset does not return the sequencer to idle.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          bus_ale,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          bus_wdata_oe,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_TW, S_T3} tstate_e;

  tstate_e       st, nxt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic          strobe_on;

  assign req_ack = rst_n && (st == S_IDLE) && req_valid;

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (req_valid) nxt = S_T1;
      S_T1:    nxt = S_T2;
      S_T2:    nxt = bus_ready ? S_T3 : S_TW;
      S_TW:    nxt = bus_ready ? S_T3 : S_TW;
      S_T3:    nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
    if (!rst_n) nxt = (st == S_TW && !bus_ready) ? S_TW : S_IDLE;
  end

  always_ff @(posedge clk) begin
    st   <= nxt;
    done <= rst_n && (st == S_T3);
    if (req_ack) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
    if (rst_n && st == S_T3 && !wr_q) rdata <= bus_rdata;
  end

  assign strobe_on    = (st == S_T2) || (st == S_TW) || (st == S_T3);
  assign bus_ale      = (st == S_T1);
  assign bus_addr     = (st != S_IDLE) ? addr_q : '0;
  assign bus_rd_n     = !(strobe_on && !wr_q);
  assign bus_wr_n     = !(strobe_on && wr_q);
  assign bus_wdata_oe = strobe_on && wr_q;
  assign bus_wdata    = bus_wdata_oe ? wdata_q : '0;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!bus_ale && bus_rd_n && bus_wr_n && !bus_wdata_oe)); // R1
  AST_ACK_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (bus_ale && !req_ack)); // R2
  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> (!bus_ale && (bus_rd_n != bus_wr_n))); // R3
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R4
  AST_READY_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 && bus_ready) |=> ##1 done); // R5
  AST_WAIT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_T2 && !bus_ready) |=> (st == S_TW)); // R6
  AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TW) |-> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_wdata_oe)
                      && $stable(bus_rd_n) && $stable(bus_wr_n) && $stable(bus_ale))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5
  AST_RESET_HOLDS_WAIT: assert property (@(posedge clk)
    (st == S_TW && !bus_ready && !rst_n) |=> (st == S_TW && $stable(bus_addr))); // R9

endmodule

// File: tb/sim_bus_cycle_seq.sv
`timescale 1ns/1ps
module sim_bus_cycle_seq;
  localparam int AW = 12;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ack, done;
  logic [DW-1:0] rdata;
  logic bus_ale, bus_wdata_oe, bus_rd_n, bus_wr_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic bus_ready = 1;
  logic [DW-1:0] bus_rdata = 8'hEE;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_cycle_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .done(done),
    .rdata(rdata), .bus_ale(bus_ale), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wdata_oe(bus_wdata_oe), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(input string req);
    check(!bus_ale && bus_rd_n && bus_wr_n && !bus_wdata_oe && bus_addr == '0, req,
          {bus_ale, bus_rd_n, bus_wr_n, bus_wdata_oe, 16'(bus_addr)}, {4'b0110, 16'h0});
  endtask

  task automatic check_strobe(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    check(bus_rd_n == wr && bus_wr_n == !wr, req, {bus_rd_n, bus_wr_n}, {wr, !wr});
    check(bus_addr == a && !bus_ale, req, {bus_ale, 16'(bus_addr)}, {1'b0, 16'(a)});
    if (wr) check(bus_wdata_oe && bus_wdata == d, req, {bus_wdata_oe, bus_wdata}, {1'b1, d});
    else    check(!bus_wdata_oe, req, bus_wdata_oe, 0);
  endtask

  task automatic t_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input int nw, input logic [DW-1:0] rv);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; bus_ready = 1; bus_rdata = 8'hEE;
    #1 check(req_ack == 1, "R2 ack in idle", req_ack, 1);
    @(negedge clk);
    req_valid = 0; req_write = !wr; req_addr = ~a; req_wdata = ~d;
    check(bus_ale == 1, "R3 ale in T1", bus_ale, 1);
    check(bus_addr == a, "R3 addr in T1", bus_addr, a);
    check(bus_rd_n && bus_wr_n, "R4 no strobe in T1", {bus_rd_n, bus_wr_n}, 2'b11);
    @(negedge clk);
    check_strobe(wr, a, d, "R4 T2 strobe");
    req_valid = 1;
    #1 check(req_ack == 0, "R2 no ack while busy", req_ack, 0);
    bus_ready = (nw == 0);
    for (int k = 1; k <= nw; k++) begin
      @(negedge clk);
      check_strobe(wr, a, d, "R7 frozen in wait");
      check(done == 0, "R6 wait adds a clock", done, 0);
      bus_ready = (k == nw);
    end
    @(negedge clk);
    req_valid = 0;
    check_strobe(wr, a, d, "R4 T3 strobe");
    check(done == 0, "R5 no done in T3", done, 0);
    bus_rdata = rv;
    @(negedge clk);
    bus_rdata = 8'hEE;
    check(done == 1, "R5 done after T3", done, 1);
    check_idle("R1 idle after cycle");
    if (!wr) check(rdata == rv, "R8 read data", rdata, rv);
    @(negedge clk);
    check(done == 0, "R5 done one clock", done, 0);
    check_idle("R1 idle stays");
  endtask

  task automatic t_reset_in_wait(input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; bus_ready = 1;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    bus_ready = 0;
    @(negedge clk);
    rst_n = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(bus_rd_n == 0 && bus_addr == a, "R9 reset holds wait", {bus_rd_n, 16'(bus_addr)}, {1'b0, 16'(a)});
    end
    bus_ready = 1;
    @(negedge clk);
    check_idle("R9 leave wait on ready");
    check(done == 0, "R9 no done on reset exit", done, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    req_valid = 1;
    repeat (3) @(negedge clk);
    check_idle("R1 reset state");
    check(req_ack == 0 && done == 0, "R2 no ack in reset", {req_ack, done}, 0);
    req_valid = 0;
    rst_n = 1;
    @(negedge clk);
    check_idle("R1 after reset release");
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_cycle(0, 12'h3A5, 8'h00, 0, 8'h5C);
    t_cycle(1, 12'hC12, 8'hA7, 0, 8'h00);
    t_cycle(0, 12'h0F0, 8'h00, 1, 8'h81);
    t_cycle(1, 12'h7E1, 8'h3C, 2, 8'h00);
    t_cycle(0, 12'hFFF, 8'h00, 5, 8'hC3);
    t_reset_in_wait(12'h456);
    t_cycle(1, 12'h001, 8'hFF, 3, 8'h00);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule